// File: doc/BRIEF.md
# Reset Cause Capture Register

This block records which internal source was behind the latest internal reset and offers that record as an 8-bit read-only status byte. Four sources can request an internal reset: an illegal-opcode detector built into the block, a watchdog, an illegal-memory-access detector and a selectable power-on-reset circuit. The last three arrive as one-cycle request pulses. The block watches the opcode fetch stream itself and raises its own illegal-instruction request when it sees the byte 0xFF. That request is blocked while the debug emulation input is high.

Any internal request drives the combined internal reset output low for a fixed number of cycles. The recorded flags live in storage that this internal reset does not touch, so software can read the cause once the system comes back. The flags are wiped only by the external pin reset or by the data-retention low-voltage reset. Both are asynchronous and active-low, and they are released through a two-stage synchroniser. A byte read returns the flags and clears them as a side effect. A single-bit access is refused: it reports an access error and changes nothing.

Top module: `rcf_reset_cause`

## Requirements
- R1: Status byte layout: bit 7 is the illegal-instruction flag, bit 4 the watchdog flag, bit 1 the illegal-memory-access flag and bit 0 the selectable power-on-reset flag. Bits 6, 5, 3 and 2 always read 0.
- R2: A request pulse sets its flag. The flag stays 1, through the internal reset it caused, until a clearing event.
- R3: When `op_valid` is high and `op_byte` is 0xFF, bit 7 is set and an internal reset starts. Any other opcode, or 0xFF without `op_valid`, has no effect.
- R4: While `dbg_emu` is high, opcode 0xFF sets no flag and does not assert `rst_int_n`.
- R5: Holding `rst_pin_n` low clears all four flags.
- R6: Holding `rst_ret_n` low clears all four flags.
- R7: A byte read (`rd_en`=1, `rd_bit`=0) places the flags as they were before that clock edge on `rd_data`, starting from the next cycle. The flags are cleared at that same edge. `rd_data` holds its value until the next byte read.
- R8: A bit access (`rd_en`=1, `rd_bit`=1) pulses `rd_err` high for one cycle after the edge. It leaves the flags and `rd_data` unchanged.
- R9: After the edge that samples any internal request, `rst_int_n` is low for exactly 16 cycles. A new request reloads the full 16-cycle window.
- R10: Requests that arrive in the same cycle all set their flags.
- R11: A request that arrives in the same cycle as a byte read leaves its flag at 1. The read returns the value from before that request.
- R12: After the external resets are released and the two-stage synchroniser finishes, `rd_data` is 0x00, `rd_err` is 0 and `rst_int_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_pin_n | input | 1 | External pin reset, asynchronous, active low |
| rst_ret_n | input | 1 | Data-retention low-voltage reset, asynchronous, active low |
| op_valid | input | 1 | Opcode fetch strobe |
| op_byte | input | 8 | Fetched opcode byte |
| dbg_emu | input | 1 | Debug emulation mode; blocks the illegal-instruction reset |
| wdt_req | input | 1 | Watchdog reset request pulse |
| iaw_req | input | 1 | Illegal-memory-access reset request pulse |
| spor_req | input | 1 | Selectable power-on-reset request pulse |
| rd_en | input | 1 | Register access strobe |
| rd_bit | input | 1 | 1 = single-bit access (refused), 0 = byte read |
| rd_data | output | 8 | Captured status byte |
| rd_err | output | 1 | Access error pulse for a bit access |
| rst_int_n | output | 1 | Combined internal reset, active low |

## Verification
The hardest case to reach from the ports is a request that lands in the exact cycle as a clearing byte read. To get there, the stimulus drives `rd_en` and a request pulse on the same falling edge. It then checks that the read returns the older flags and that the following read still shows the new flag. A second hard case is reloading the internal reset window: a second request arrives part way through an active window, and the stimulus counts the low cycles that follow it. A behavioural model runs alongside and compares all outputs on every cycle, including the cycles around both asynchronous reset releases.

// File: rtl/rcf_pkg.sv
package rcf_pkg;

  localparam int unsigned NUM_SRC = 4;
  localparam int unsigned STAT_W  = 8;

  // Internal source index (vector position inside the flag store)
  typedef enum logic [1:0] {
    SRC_SPOR = 2'd0,
    SRC_IAW  = 2'd1,
    SRC_WDT  = 2'd2,
    SRC_ILL  = 2'd3
  } src_e;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  // Bit position of each source inside the visible status byte
  function automatic int unsigned stat_pos(input int unsigned src);
    int unsigned pos;
    case (src)
      0:       pos = 0;
      1:       pos = 1;
      2:       pos = 4;
      default: pos = 7;
    endcase
    return pos;
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(input src_vec_t flg);
    logic [STAT_W-1:0] stat;
    stat = '0;
    for (int unsigned k = 0; k < NUM_SRC; k++) begin
      stat[stat_pos(k)] = flg[k];
    end
    return stat;
  endfunction

endpackage

// File: rtl/rcf_rst_sync.sv
module rcf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/rcf_illop_det.sv
module rcf_illop_det #(
  parameter int unsigned OP_W     = 8,
  parameter logic [OP_W-1:0] ILL_CODE = '1
) (
  input  logic            op_valid,
  input  logic [OP_W-1:0] op_byte,
  input  logic            dbg_emu,
  output logic            ill_req
);

  logic code_hit;

  always_comb begin
    code_hit = (op_byte == ILL_CODE);
    ill_req  = op_valid & code_hit & ~dbg_emu;
  end

endmodule

// File: rtl/rcf_flags.sv
module rcf_flags #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_o
);

  logic [N-1:0] flags_q;
  logic [N-1:0] flags_d;
  logic         upd_en;

  // A set in the same cycle as a clear wins
  always_comb begin
    upd_en  = clr_i | (|set_i);
    flags_d = (flags_q & ~{N{clr_i}}) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (upd_en) begin
      flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;

endmodule

// File: rtl/rcf_stretch.sv
module rcf_stretch #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic active_o
);

  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (trig_i) begin
      cnt_d  = CW'(CYCLES);
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - CW'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign active_o = (cnt_q != '0);

endmodule

// File: rtl/rcf_reset_cause.sv
module rcf_reset_cause
  import rcf_pkg::*;
#(
  parameter int unsigned        OP_W        = 8,
  parameter logic [OP_W-1:0]    ILL_OPCODE  = 8'hFF,
  parameter int unsigned        RST_CYCLES  = 16,
  parameter int unsigned        SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_pin_n,
  input  logic              rst_ret_n,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_byte,
  input  logic              dbg_emu,
  input  logic              wdt_req,
  input  logic              iaw_req,
  input  logic              spor_req,
  input  logic              rd_en,
  input  logic              rd_bit,
  output logic [STAT_W-1:0] rd_data,
  output logic              rd_err,
  output logic              rst_int_n
);

  logic              arst_n;
  logic              rst_sys_n;
  logic              ill_req;
  src_vec_t          set_vec;
  src_vec_t          flags;
  logic              any_req;
  logic              rd_byte;
  logic              rd_bitacc;
  logic              int_active;
  logic [STAT_W-1:0] rd_data_q;
  logic [STAT_W-1:0] rd_data_d;
  logic              rd_err_q;
  logic              rd_err_d;

  // Only the pin and retention resets reach the flag storage
  assign arst_n = rst_pin_n & rst_ret_n;

  rcf_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_sys_n)
  );

  rcf_illop_det #(
    .OP_W     (OP_W),
    .ILL_CODE (ILL_OPCODE)
  ) u_illop (
    .op_valid (op_valid),
    .op_byte  (op_byte),
    .dbg_emu  (dbg_emu),
    .ill_req  (ill_req)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[SRC_SPOR] = spor_req;
    set_vec[SRC_IAW]  = iaw_req;
    set_vec[SRC_WDT]  = wdt_req;
    set_vec[SRC_ILL]  = ill_req;
    any_req           = |set_vec;
    rd_byte           = rd_en & ~rd_bit;
    rd_bitacc         = rd_en & rd_bit;
  end

  rcf_flags #(
    .N (NUM_SRC)
  ) u_flags (
    .clk     (clk),
    .rst_n   (rst_sys_n),
    .set_i   (set_vec),
    .clr_i   (rd_byte),
    .flags_o (flags)
  );

  rcf_stretch #(
    .CYCLES (RST_CYCLES)
  ) u_stretch (
    .clk      (clk),
    .rst_n    (rst_sys_n),
    .trig_i   (any_req),
    .active_o (int_active)
  );

  // Read port: capture on byte read, error pulse on bit access
  always_comb begin
    rd_data_d = rd_data_q;
    if (rd_byte) begin
      rd_data_d = pack_status(flags);
    end
    rd_err_d = rd_bitacc;
  end

  always_ff @(posedge clk or negedge rst_sys_n) begin
    if (!rst_sys_n) begin
      rd_data_q <= '0;
    end else if (rd_byte) begin
      rd_data_q <= rd_data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sys_n) begin
    if (!rst_sys_n) begin
      rd_err_q <= 1'b0;
    end else if (rd_err_q | rd_bitacc) begin
      rd_err_q <= rd_err_d;
    end
  end

  assign rd_data   = rd_data_q;
  assign rd_err    = rd_err_q;
  assign rst_int_n = ~int_active;

endmodule

// File: rtl/rcf_reset_cause_chk.sv
module rcf_reset_cause_chk (
  input logic       clk,
  input logic       rst_sys_n,
  input logic       op_valid,
  input logic [7:0] op_byte,
  input logic       dbg_emu,
  input logic       ill_req,
  input logic       wdt_req,
  input logic       iaw_req,
  input logic       spor_req,
  input logic       rd_en,
  input logic       rd_bit,
  input logic [3:0] flags,
  input logic [7:0] rd_data,
  input logic       rd_err,
  input logic       rst_int_n
);

  logic any_req;
  assign any_req = ill_req | wdt_req | iaw_req | spor_req;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_sys_n)
    (rd_data[6:5] == 2'b00) && (rd_data[3:2] == 2'b00)); // R1

  for (genvar g = 0; g < 4; g++) begin : g_sticky
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_sys_n)
      (flags[g] && !(rd_en && !rd_bit)) |=> flags[g]); // R2
  end

  AST_ILL_SETS: assert property (@(posedge clk) disable iff (!rst_sys_n)
    (op_valid && (op_byte == 8'hFF) && !dbg_emu) |=> flags[3]); // R3

  AST_DBG_BLOCKS: assert property (@(posedge clk) disable iff (!rst_sys_n)
    dbg_emu |-> !ill_req); // R4

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_sys_n)
    (rd_en && !rd_bit && !any_req) |=> (flags == 4'b0000)); // R7

  AST_BIT_ERR: assert property (@(posedge clk) disable iff (!rst_sys_n)
    (rd_en && rd_bit) |=> rd_err); // R8

  AST_BIT_KEEPS: assert property (@(posedge clk) disable iff (!rst_sys_n)
    (rd_en && rd_bit && !any_req) |=> ($stable(flags) && $stable(rd_data))); // R8

  AST_REQ_RESETS: assert property (@(posedge clk) disable iff (!rst_sys_n)
    any_req |=> !rst_int_n); // R9

  AST_MULTI_SET: assert property (@(posedge clk) disable iff (!rst_sys_n)
    (wdt_req && spor_req) |=> (flags[2] && flags[0])); // R10

  AST_REQ_WINS: assert property (@(posedge clk) disable iff (!rst_sys_n)
    (wdt_req && rd_en && !rd_bit) |=> flags[2]); // R11

endmodule

bind rcf_reset_cause rcf_reset_cause_chk u_chk (
  .clk       (clk),
  .rst_sys_n (rst_sys_n),
  .op_valid  (op_valid),
  .op_byte   (op_byte),
  .dbg_emu   (dbg_emu),
  .ill_req   (ill_req),
  .wdt_req   (wdt_req),
  .iaw_req   (iaw_req),
  .spor_req  (spor_req),
  .rd_en     (rd_en),
  .rd_bit    (rd_bit),
  .flags     (flags),
  .rd_data   (rd_data),
  .rd_err    (rd_err),
  .rst_int_n (rst_int_n)
);

// File: tb/rcf_reset_cause_tb.sv
module rcf_reset_cause_tb;

  localparam int CLK_P = 10;

  logic       clk;
  logic       rst_pin_n, rst_ret_n;
  logic       op_valid;
  logic [7:0] op_byte;
  logic       dbg_emu;
  logic       wdt_req, iaw_req, spor_req;
  logic       rd_en, rd_bit;
  logic [7:0] rd_data;
  logic       rd_err;
  logic       rst_int_n;

  int n_chk;
  int n_fail;
  bit cmp_on;
  bit done;

  // reference model state
  int         m_sync;
  logic [7:0] m_stat;
  logic [7:0] m_data;
  logic       m_err;
  int         m_cnt;

  rcf_reset_cause u_dut (
    .clk       (clk),
    .rst_pin_n (rst_pin_n),
    .rst_ret_n (rst_ret_n),
    .op_valid  (op_valid),
    .op_byte   (op_byte),
    .dbg_emu   (dbg_emu),
    .wdt_req   (wdt_req),
    .iaw_req   (iaw_req),
    .spor_req  (spor_req),
    .rd_en     (rd_en),
    .rd_bit    (rd_bit),
    .rd_data   (rd_data),
    .rd_err    (rd_err),
    .rst_int_n (rst_int_n)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    logic [7:0] setv;
    if (!rst_pin_n || !rst_ret_n) begin
      m_sync = 0; m_stat = 8'h00; m_data = 8'h00; m_err = 1'b0; m_cnt = 0;
    end else if (m_sync < 2) begin
      m_sync = m_sync + 1;
    end else begin
      setv = 8'h00;
      if (op_valid && op_byte == 8'hFF && !dbg_emu) setv[7] = 1'b1;
      if (wdt_req)  setv[4] = 1'b1;
      if (iaw_req)  setv[1] = 1'b1;
      if (spor_req) setv[0] = 1'b1;
      m_err = rd_en && rd_bit;
      if (rd_en && !rd_bit) begin
        m_data = m_stat;
        m_stat = 8'h00;
      end
      m_stat = m_stat | setv;
      if (setv != 8'h00) m_cnt = 16;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
    end
  end

  // Per-cycle comparison a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_P/4);
    if (cmp_on) begin
      chk(rd_data == m_data, "R7", int'(rd_data), int'(m_data));
      chk(rd_err == m_err, "R8", int'(rd_err), int'(m_err));
      chk(rst_int_n == (m_cnt == 0), "R9", int'(rst_int_n), int'(m_cnt == 0));
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse(input logic w, input logic i, input logic s,
                       input logic ov, input logic [7:0] ob, input logic dbg);
    wdt_req = w; iaw_req = i; spor_req = s;
    op_valid = ov; op_byte = ob; dbg_emu = dbg;
    tick();
    wdt_req = 0; iaw_req = 0; spor_req = 0;
    op_valid = 0; op_byte = 8'h00; dbg_emu = 0;
  endtask

  task automatic do_read(input logic [7:0] exp, input string req);
    rd_en = 1; rd_bit = 0;
    tick();
    rd_en = 0;
    chk(rd_data == exp, req, int'(rd_data), int'(exp));
  endtask

  task automatic count_low(output int n);
    n = 0;
    while (!rst_int_n && n < 100) begin
      n++;
      tick();
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int nl;
    n_chk = 0; n_fail = 0; cmp_on = 0; done = 0;
    rst_pin_n = 0; rst_ret_n = 0;
    op_valid = 0; op_byte = 8'h00; dbg_emu = 0;
    wdt_req = 0; iaw_req = 0; spor_req = 0;
    rd_en = 0; rd_bit = 0;
    tick();
    cmp_on = 1;
    repeat (2) tick();
    rst_pin_n = 1; rst_ret_n = 1;
    repeat (3) tick();
    chk(rst_int_n == 1'b1, "R12", int'(rst_int_n), 1);
    chk(rd_data == 8'h00, "R12", int'(rd_data), 0);
    chk(rd_err == 1'b0, "R12", int'(rd_err), 0);
    do_read(8'h00, "R1");

    // watchdog: window length and sticky flag
    pulse(1, 0, 0, 0, 8'h00, 0);
    count_low(nl);
    chk(nl == 16, "R9", nl, 16);
    do_read(8'h10, "R2");
    do_read(8'h00, "R7");

    // opcode detection
    pulse(0, 0, 0, 1, 8'hFE, 0);
    pulse(0, 0, 0, 0, 8'hFF, 0);
    tick();
    chk(rst_int_n == 1'b1, "R3", int'(rst_int_n), 1);
    do_read(8'h00, "R3");
    pulse(0, 0, 0, 1, 8'hFF, 0);
    count_low(nl);
    chk(nl == 16, "R3", nl, 16);
    do_read(8'h80, "R3");
    pulse(0, 0, 0, 1, 8'hFF, 1);
    chk(rst_int_n == 1'b1, "R4", int'(rst_int_n), 1);
    do_read(8'h00, "R4");

    // simultaneous requests
    pulse(1, 1, 1, 1, 8'hFF, 0);
    do_read(8'h93, "R10");

    // bit access refused
    pulse(0, 0, 1, 0, 8'h00, 0);
    rd_en = 1; rd_bit = 1;
    tick();
    rd_en = 0; rd_bit = 0;
    chk(rd_err == 1'b1, "R8", int'(rd_err), 1);
    chk(rd_data == 8'h93, "R8", int'(rd_data), 8'h93);
    tick();
    chk(rd_err == 1'b0, "R8", int'(rd_err), 0);
    do_read(8'h01, "R8");

    // request in the cycle of a clearing read
    pulse(0, 1, 0, 0, 8'h00, 0);
    rd_en = 1; rd_bit = 0; wdt_req = 1;
    tick();
    rd_en = 0; wdt_req = 0;
    chk(rd_data == 8'h02, "R11", int'(rd_data), 8'h02);
    do_read(8'h10, "R11");

    // retrigger of the internal reset window
    pulse(1, 0, 0, 0, 8'h00, 0);
    repeat (5) tick();
    pulse(0, 1, 0, 0, 8'h00, 0);
    count_low(nl);
    chk(nl == 16, "R9", nl, 16);
    do_read(8'h12, "R9");

    // external pin reset clears
    pulse(1, 1, 0, 0, 8'h00, 0);
    rst_pin_n = 0;
    repeat (2) tick();
    rst_pin_n = 1;
    repeat (3) tick();
    do_read(8'h00, "R5");

    // retention reset clears
    pulse(0, 0, 1, 1, 8'hFF, 0);
    repeat (3) tick();
    rst_ret_n = 0;
    repeat (2) tick();
    rst_ret_n = 1;
    repeat (3) tick();
    chk(rst_int_n == 1'b1, "R6", int'(rst_int_n), 1);
    do_read(8'h00, "R6");

    repeat (3) tick();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule